// File: doc/BRIEF.md
# Configuration Register Slave on a Two-Wire Bus

This block is the serial front end of a programmable clock divider. It listens to an already synchronized two-wire serial bus (SCL and SDA), answers as a slave, and holds three configuration words: a 16-bit mode word, a 16-bit divisor word and an 8-bit bus word that carries the slave's own 3-bit select code and a commit-control flag. A master addresses the block with a control byte, then sends a command byte that picks a register, then either writes data bytes or issues a repeated START and reads the register back.

Changes to the registers are copied to a nonvolatile store. That store is modelled here only as a busy interval of fixed length started by a one-cycle commit pulse. Whether a write triggers a commit depends on the commit-control flag; writing the bus word always triggers one, and a dedicated command triggers one on demand. While a commit is busy the slave refuses every transfer addressed to it. The SDA pin is driven open-drain: `sda_oe_o` high pulls the line low, otherwise the line is released.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The control byte is, MSB first, the code 1011, then three select bits that must equal bus word bits 2..0, then a direction bit (1 = read); only a matching byte is acknowledged, any other leaves the slave silent until the next START.
- R2: Command 0x01 selects the divisor word, 0x02 the mode word and 0x0D the bus word; write data arrive MSB byte first, and a 16-bit word takes both bytes together when its second byte is accepted, while a STOP or START after only the MSB byte replaces the upper byte and keeps the lower one.
- R3: A read is a write of the command byte, a repeated START and the control byte with the direction bit at 1; a 16-bit word returns its MSB byte then its LSB byte, the bus word returns one byte, and every byte past the word's width reads as 0xFF.
- R4: The bus word holds the commit-control flag in bit 3 and the select code in bits 2..0; bits 7..4 always read 0 and the word resets to 0x00.
- R5: With the commit-control flag at 0, a transfer that updated a register ends in one `commit_o` pulse on the cycle after its STOP; with the flag at 1, mode and divisor writes raise no pulse, and command 0x3F raises one at the following STOP.
- R6: A write to the bus word raises a commit pulse at the STOP whatever the commit-control flag holds.
- R7: `nv_busy_o` is high for exactly NV_CYCLES cycles starting the cycle after a commit pulse, and a control byte that would otherwise match is not acknowledged during that time.
- R8: When the master does not acknowledge a read byte, the slave releases SDA and sends nothing more until the next START.
- R9: While `pdn_i` is high, write data bytes are not acknowledged and no register changes.
- R10: A START or STOP in the middle of a byte discards the partial byte; after a START the next eight bits are taken as a fresh control byte.
- R11: Write data bytes beyond the selected word's width are acknowledged and have no effect.
- R12: After reset the mode word is 0x1800, the divisor word 0x0000, the bus word 0x00, SDA is released and `nv_busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock, already synchronized to clk |
| sda_i | input | 1 | Serial data line level, already synchronized to clk |
| pdn_i | input | 1 | Power-down state; blocks register writes |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| mode_o | output | 16 | Mode word |
| div_o | output | 16 | Divisor word |
| bus_o | output | 8 | Bus word (commit flag, select code) |
| commit_o | output | 1 | One-cycle request to copy all registers to storage |
| nv_busy_o | output | 1 | Storage copy in progress |

## Verification
The assertions assume a well-behaved master: SDA changes only while SCL is low except to form START and STOP, a START or STOP is never issued while the slave holds SDA low, and every SCL phase lasts several clock cycles so that each edge is seen as a separate event. The stimulus bit-bangs the bus with each SCL quarter-phase held for four clocks, changes SDA a full quarter after SCL falls, and models the line as the wired AND of master and slave, so the slave's acknowledge and read bits appear on the line the master samples. Power-down is only changed between transfers.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_TX} link_st_e;
  typedef enum logic [1:0] {BK_ADDR, BK_CMD, BK_DATA} byte_kind_e;

  localparam logic [3:0] DEV_CODE = 4'b1011;
  localparam logic [7:0] CMD_DIV  = 8'h01;
  localparam logic [7:0] CMD_MODE = 8'h02;
  localparam logic [7:0] CMD_BUS  = 8'h0D;
  localparam logic [7:0] CMD_SAVE = 8'h3F;
  localparam int WC_BIT = 3;
endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise = !scl_q && scl_i;
  assign scl_fall = scl_q && !scl_i;
  assign start_ev = scl_q && scl_i && sda_q && !sda_i;
  assign stop_ev  = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/nv_busy_timer.sv
module nv_busy_timer #(
  parameter int NV_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(NV_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (start)       cnt <= CW'(NV_CYCLES);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfg_i2c_pkg::*;
#(
  parameter int          NV_CYCLES = 400,
  parameter logic [15:0] MODE_RST  = 16'h1800,
  parameter logic [15:0] DIV_RST   = 16'h0000,
  parameter logic [7:0]  BUS_RST   = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        pdn_i,
  output logic        sda_oe_o,
  output logic [15:0] mode_o,
  output logic [15:0] div_o,
  output logic [7:0]  bus_o,
  output logic        commit_o,
  output logic        nv_busy_o
);
  localparam int BYTE_W = 8;
  localparam logic [3:0] BITS_FULL = 4'(BYTE_W);

  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2c_line_events i_events (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  logic commit_q, busy;

  nv_busy_timer #(.NV_CYCLES(NV_CYCLES)) i_timer (
    .clk(clk), .rst_n(rst_n), .start(commit_q), .busy(busy)
  );

  link_st_e          st;
  byte_kind_e        kind;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] sh, tx, ptr, rd_byte;
  logic              in_ack, ack_drv, go_rd, in_mack, mack_ok;
  logic [1:0]        byte_idx, ptr_w, idx_inc;
  logic [15:0]       mode_q, div_q, stage, stage_nx, apply_val;
  logic [7:0]        bus_q;
  logic              wr_pend, commit_flag;
  logic              byte_end, cmd_done, data_done, data_take, apply_fire, apply_commit;

  // ---- decode of the selected word ----
  always_comb begin
    unique case (ptr)
      CMD_DIV, CMD_MODE: ptr_w = 2'd2;
      CMD_BUS:           ptr_w = 2'd1;
      default:           ptr_w = 2'd0;
    endcase
    rd_byte = 8'hFF;
    if (byte_idx < ptr_w) begin
      unique case (ptr)
        CMD_DIV:  rd_byte = (byte_idx == 2'd0) ? div_q[15:8]  : div_q[7:0];
        CMD_MODE: rd_byte = (byte_idx == 2'd0) ? mode_q[15:8] : mode_q[7:0];
        default:  rd_byte = bus_q;
      endcase
    end
  end

  assign idx_inc   = (byte_idx == 2'd3) ? 2'd3 : byte_idx + 2'd1;
  assign byte_end  = (st == ST_RX) && scl_fall && !in_ack && (bitcnt == BITS_FULL);
  assign cmd_done  = byte_end && (kind == BK_CMD);
  assign data_done = byte_end && (kind == BK_DATA);
  assign data_take = data_done && !pdn_i && (byte_idx < ptr_w);
  assign stage_nx  = (byte_idx == 2'd0) ? {sh, stage[7:0]} : {stage[15:8], sh};
  assign apply_val = data_take ? stage_nx : stage;
  assign apply_fire = !pdn_i &&
                      ((data_take && (byte_idx == ptr_w - 2'd1)) ||
                       ((start_ev || stop_ev) && wr_pend));
  assign apply_commit = apply_fire && ((ptr == CMD_BUS) || !bus_q[WC_BIT]);

  // ---- bit and byte sequencing ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; kind <= BK_ADDR; bitcnt <= '0; sh <= '0; tx <= 8'hFF;
      in_ack <= 1'b0; ack_drv <= 1'b0; go_rd <= 1'b0; in_mack <= 1'b0;
      mack_ok <= 1'b0; ptr <= '0; byte_idx <= '0;
    end else if (start_ev) begin
      st <= ST_RX; kind <= BK_ADDR; bitcnt <= '0; tx <= 8'hFF;
      in_ack <= 1'b0; ack_drv <= 1'b0; in_mack <= 1'b0;
    end else if (stop_ev) begin
      st <= ST_IDLE; tx <= 8'hFF; in_ack <= 1'b0; ack_drv <= 1'b0; in_mack <= 1'b0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise && !in_ack && bitcnt != BITS_FULL) begin
            sh     <= {sh[BYTE_W-2:0], sda_i};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && in_ack) begin
            in_ack  <= 1'b0;
            ack_drv <= 1'b0;
            bitcnt  <= '0;
            if (!ack_drv) st <= ST_IDLE;
            else if (go_rd) begin
              st       <= ST_TX;
              tx       <= rd_byte;
              byte_idx <= idx_inc;
            end
          end else if (byte_end) begin
            in_ack <= 1'b1;
            unique case (kind)
              BK_ADDR: begin
                ack_drv  <= (sh[7:4] == DEV_CODE) && (sh[3:1] == bus_q[2:0]) && !busy;
                go_rd    <= sh[0];
                byte_idx <= '0;
                kind     <= BK_CMD;
              end
              BK_CMD: begin
                ack_drv  <= 1'b1;
                ptr      <= sh;
                byte_idx <= '0;
                kind     <= BK_DATA;
              end
              default: begin
                ack_drv <= !pdn_i;
                if (!pdn_i) byte_idx <= idx_inc;
              end
            endcase
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            if (in_mack) mack_ok <= !sda_i;
            else         bitcnt  <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (in_mack) begin
              in_mack <= 1'b0;
              if (mack_ok) begin
                tx       <= rd_byte;
                byte_idx <= idx_inc;
                bitcnt   <= '0;
              end else begin
                st <= ST_IDLE;
              end
            end else if (bitcnt == BITS_FULL) begin
              in_mack <= 1'b1;
              tx      <= 8'hFF;
            end else begin
              tx <= {tx[BYTE_W-2:0], 1'b1};
            end
          end
        end
        default: ;
      endcase
    end
  end

  // ---- register file, staging and commit requests ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST; div_q <= DIV_RST; bus_q <= BUS_RST & 8'h0F;
      stage <= '0; wr_pend <= 1'b0; commit_flag <= 1'b0; commit_q <= 1'b0;
    end else begin
      commit_q <= stop_ev && !busy && (commit_flag || apply_commit);
      if (stop_ev)                              commit_flag <= 1'b0;
      else if (apply_commit || (cmd_done && sh == CMD_SAVE)) commit_flag <= 1'b1;

      if (cmd_done) begin
        unique case (sh)
          CMD_DIV:  stage <= div_q;
          CMD_MODE: stage <= mode_q;
          CMD_BUS:  stage <= {bus_q, 8'h00};
          default:  stage <= '0;
        endcase
      end else if (data_take) begin
        stage <= stage_nx;
      end

      if (apply_fire) begin
        unique case (ptr)
          CMD_DIV:  div_q  <= apply_val;
          CMD_MODE: mode_q <= apply_val;
          default:  bus_q  <= apply_val[15:8] & 8'h0F;
        endcase
      end

      if (apply_fire || start_ev || stop_ev || cmd_done) wr_pend <= 1'b0;
      else if (data_take)                                 wr_pend <= 1'b1;
    end
  end

  assign sda_oe_o  = ((st == ST_RX) && ack_drv) || ((st == ST_TX) && !tx[BYTE_W-1]);
  assign mode_o    = mode_q;
  assign div_o     = div_q;
  assign bus_o     = bus_q;
  assign commit_o  = commit_q;
  assign nv_busy_o = busy;
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
  parameter int NV_CYCLES = 400
) (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_i,
  input logic        pdn_i,
  input logic        sda_oe_o,
  input logic [15:0] mode_o,
  input logic [15:0] div_o,
  input logic [7:0]  bus_o,
  input logic        commit_o,
  input logic        nv_busy_o
);
  int busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_run <= 0;
    else if (nv_busy_o) busy_run <= busy_run + 1;
    else                busy_run <= 0;
  end

  p_busy_follows_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> nv_busy_o);

  p_busy_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy_o |-> (busy_run < NV_CYCLES));

  p_commit_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> ($past(scl_i, 2) && $past(scl_i) && !$past(sda_i, 2) && $past(sda_i)));

  p_bus_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_o[7:4] == 4'h0);

  p_regs_hold_in_pdn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pdn_i) |-> ($stable(mode_o) && $stable(div_o) && $stable(bus_o)));

  p_sda_steady_scl_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.NV_CYCLES(NV_CYCLES)) i_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .pdn_i(pdn_i),
  .sda_oe_o(sda_oe_o), .mode_o(mode_o), .div_o(div_o), .bus_o(bus_o),
  .commit_o(commit_o), .nv_busy_o(nv_busy_o)
);

// File: tb/test_cfg_i2c_slave.sv
module test_cfg_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam int NV = 400;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, pdn = 1'b0;
  logic sda_oe_o, commit_o, nv_busy_o;
  logic [15:0] mode_o, div_o;
  logic [7:0] bus_o;
  wire sda_line = sda_m & ~sda_oe_o;

  int n_chk = 0, n_fail = 0, n_commit = 0, n_busy = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_i2c_slave #(.NV_CYCLES(NV)) i_cfg_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .pdn_i(pdn),
    .sda_oe_o(sda_oe_o), .mode_o(mode_o), .div_o(div_o), .bus_o(bus_o),
    .commit_o(commit_o), .nv_busy_o(nv_busy_o)
  );

  always @(posedge clk) begin
    if (commit_o)  n_commit++;
    if (nv_busy_o) n_busy++;
  end

  // {cmd, nbytes, b0, b1, b2, expected word}
  localparam logic [55:0] VEC [6] = '{
    {8'h01, 8'd2, 8'h03, 8'hFF, 8'h00, 16'h03FF},
    {8'h02, 8'd2, 8'h0C, 8'h40, 8'h00, 16'h0C40},
    {8'h01, 8'd2, 8'h00, 8'h02, 8'h00, 16'h0002},
    {8'h01, 8'd1, 8'hA5, 8'h00, 8'h00, 16'hA502},
    {8'h02, 8'd3, 8'h11, 8'h22, 8'h33, 16'h1122},
    {8'h0D, 8'd1, 8'hF8, 8'h00, 8'h00, 16'h0008}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] ctl(input logic [2:0] a, input logic rw);
    return {4'b1011, a, rw};
  endfunction

  task automatic i2c_start();
    sda_m = 1'b1; hold(Q); scl = 1'b1; hold(Q); sda_m = 1'b0; hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hold(Q); scl = 1'b1; hold(Q); sda_m = 1'b1; hold(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; hold(Q); scl = 1'b1; hold(2*Q); scl = 1'b0; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; hold(Q); scl = 1'b1; hold(Q); ack = !sda_line; hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic read_byte(output logic [7:0] b, input logic mack);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; hold(Q); scl = 1'b1; hold(Q); b = {b[6:0], sda_line}; hold(Q); scl = 1'b0;
    end
    hold(Q); sda_m = !mack; hold(Q); scl = 1'b1; hold(2*Q); scl = 1'b0; hold(Q); sda_m = 1'b1;
  endtask

  task automatic bus_write(input logic [7:0] ab, input logic [7:0] cmd, input int n,
                           input logic [7:0] d0, d1, d2, output logic [4:0] ak);
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2; ak = '0;
    i2c_start();
    send_byte(ab, ak[0]);
    if (ak[0]) begin
      send_byte(cmd, ak[1]);
      for (int i = 0; i < n; i++) send_byte(d[i], ak[2+i]);
    end
    i2c_stop();
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [7:0] cmd, input int n,
                          output logic [23:0] data, output logic ok);
    logic a0, a1, a2;
    logic [7:0] b;
    data = '0; a1 = 1'b0; a2 = 1'b0;
    i2c_start();
    send_byte(ctl(a, 1'b0), a0);
    if (a0) begin
      send_byte(cmd, a1);
      i2c_start();
      send_byte(ctl(a, 1'b1), a2);
      if (a2) for (int i = 0; i < n; i++) begin
        read_byte(b, i != n - 1);
        data = {data[15:0], b};
      end
    end
    i2c_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic wait_idle();
    hold(2);
    while (nv_busy_o) hold(1);
    hold(Q);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [4:0] ak;
    logic [23:0] rd;
    logic ok;
    logic [7:0] b;
    int c0;

    hold(5); rst_n = 1'b1; hold(3);
    // R12 reset values
    check("R12 mode reset", 32'(mode_o), 32'h1800);
    check("R12 div reset", 32'(div_o), 32'h0);
    check("R12 bus reset", 32'(bus_o), 32'h0);
    check("R12 sda released", 32'(sda_oe_o), 32'h0);
    check("R12 not busy", 32'(nv_busy_o), 32'h0);

    // Vector loop: R2 write order, R3 readback, R5 auto commit, R6, R11, R4
    for (int v = 0; v < 6; v++) begin
      logic [7:0] cmd, n;
      logic [15:0] exp;
      cmd = VEC[v][55:48]; n = VEC[v][47:40]; exp = VEC[v][15:0];
      c0 = n_commit;
      bus_write(ctl(3'd0, 1'b0), cmd, int'(n), VEC[v][39:32], VEC[v][31:24], VEC[v][23:16], ak);
      check("R11 R2 data acks", 32'(ak), (n == 3) ? 32'h1F : (n == 2) ? 32'h0F : 32'h07);
      wait_idle();
      check("R5 R6 one commit per write", 32'(n_commit - c0), 32'd1);
      if (cmd == 8'h01)      check("R2 divisor word", 32'(div_o), 32'(exp));
      else if (cmd == 8'h02) check("R2 mode word", 32'(mode_o), 32'(exp));
      else                   check("R4 bus reserved bits zero", 32'(bus_o), 32'(exp));
      bus_read(3'd0, cmd, (cmd == 8'h0D) ? 1 : 2, rd, ok);
      check("R3 readback ok", 32'(ok), 32'd1);
      check("R3 readback data", 32'(rd[15:0]), (cmd == 8'h0D) ? 32'(exp[7:0]) : 32'(exp));
    end

    // R5: flag set, divisor write commits nothing; 0x3F commits
    c0 = n_commit;
    bus_write(ctl(3'd0, 1'b0), 8'h01, 2, 8'h01, 8'h23, 8'h00, ak);
    hold(Q);
    check("R5 no commit with flag set", 32'(n_commit - c0), 32'd0);
    check("R5 divisor written", 32'(div_o), 32'h0123);
    n_busy = 0;
    bus_write(ctl(3'd0, 1'b0), 8'h3F, 0, 8'h00, 8'h00, 8'h00, ak);
    check("R5 save command commits", 32'(n_commit - c0), 32'd1);
    // R7: refused while busy
    check("R7 busy after commit", 32'(nv_busy_o), 32'd1);
    bus_write(ctl(3'd0, 1'b0), 8'h01, 2, 8'hDE, 8'hAD, 8'h00, ak);
    check("R7 address NACK while busy", 32'(ak[0]), 32'd0);
    check("R7 register untouched", 32'(div_o), 32'h0123);
    wait_idle();
    check("R7 busy length", 32'(n_busy), 32'(NV));

    // R6 + R1: bus word write with flag set still commits; new select code
    c0 = n_commit;
    bus_write(ctl(3'd0, 1'b0), 8'h0D, 1, 8'h05, 8'h00, 8'h00, ak);
    wait_idle();
    check("R6 forced commit", 32'(n_commit - c0), 32'd1);
    bus_read(3'd0, 8'h01, 2, rd, ok);
    check("R1 old select code refused", 32'(ok), 32'd0);
    bus_read(3'd5, 8'h01, 2, rd, ok);
    check("R1 new select code", 32'({ok, rd[15:0]}), 32'h1_0123);
    bus_write(8'b1010_1010, 8'h01, 0, 8'h00, 8'h00, 8'h00, ak);
    check("R1 wrong code NACK", 32'(ak[0]), 32'd0);

    // R9: power-down blocks writes
    pdn = 1'b1; hold(Q);
    c0 = n_commit;
    bus_write(ctl(3'd5, 1'b0), 8'h02, 2, 8'hAA, 8'hBB, 8'h00, ak);
    hold(Q);
    check("R9 data NACK in power-down", 32'(ak[2]), 32'd0);
    check("R9 mode unchanged", 32'(mode_o), 32'h1122);
    check("R9 no commit", 32'(n_commit - c0), 32'd0);
    pdn = 1'b0; hold(Q);

    // R10: START mid byte, then a fresh control byte
    i2c_start();
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    i2c_start();
    send_byte(ctl(3'd5, 1'b0), ak[0]);
    send_byte(8'h01, ak[1]);
    send_byte(8'h04, ak[2]);
    send_byte(8'h56, ak[3]);
    i2c_stop();
    wait_idle();
    check("R10 restart after aborted byte", 32'({ak[3:0], div_o}), 32'hF_0456);
    // R10: STOP mid data byte
    i2c_start();
    send_byte(ctl(3'd5, 1'b0), ak[0]);
    send_byte(8'h02, ak[1]);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    i2c_stop();
    hold(Q);
    check("R10 partial byte discarded", 32'(mode_o), 32'h1122);

    // R8: master NACK ends read and releases SDA
    i2c_start();
    send_byte(ctl(3'd5, 1'b0), ak[0]);
    send_byte(8'h01, ak[1]);
    i2c_start();
    send_byte(ctl(3'd5, 1'b1), ak[2]);
    read_byte(b, 1'b0);
    check("R8 first byte", 32'(b), 32'h04);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    check("R8 SDA released after NACK", 32'(sda_oe_o), 32'd0);
    i2c_stop();

    // R3: bytes past the width read 0xFF
    bus_read(3'd5, 8'h0D, 2, rd, ok);
    check("R3 past width", 32'(rd[15:0]), 32'h05FF);

    finish_run();
  end
endmodule